// File: doc/BRIEF.md
# Dual-Mode Byte Channel with Parasite Interrupt

This block is one two-way data channel between a host processor and a second, parasite processor. Each direction has a small byte FIFO. The host writes bytes that the parasite reads, and the parasite writes bytes that the host reads. Each side sees a data-available flag for the FIFO it reads and a not-full flag for the FIFO it writes.

A mode bit selects how the channel transfers data. In single-byte mode each FIFO behaves as a one-byte mailbox. In paired mode the flags move only on whole byte pairs, so the reader is not told about half a pair and the writer is not stopped in the middle of one. An enable bit gates a non-maskable interrupt request toward the parasite. The request is raised when the parasite has data to read, or when it may write into its outgoing FIFO.

A hard reset clears both control bits and empties the channel. It then places one dummy byte in the parasite-to-host FIFO, so the outgoing FIFO does not look empty right after reset. A soft-reset strobe on the control port applies the same channel initialisation and leaves both control bits as they were.

Top module: `dual_mode_byte_channel`

## Requirements
- R1: After a hard reset (`rst` high at a clock edge, synchronous), the outputs are as follows. `mode_o` and `irq_en_o` are 0, and both read-data outputs are 0x00. `par_avail` is 0 and `host_nfull` is 1. The parasite-to-host FIFO holds one dummy byte of value 0x00, so `host_avail` is 1, `par_nfull` is 0 and `par_nmi` is 0.
- R2: In single-byte mode, a byte written with `host_wr` is returned on `par_rdata` by the next accepted `par_rd`. A byte written with `par_wr` is returned on `host_rdata` by the next accepted `host_rd`. The bytes are unchanged.
- R3: In single-byte mode (`mode_o`=0), data-available is 1 while the FIFO holds at least one byte. Not-full is 1 only while the FIFO is empty. A write while not-full is 0 is ignored.
- R4: In paired mode (`mode_o`=1), data-available stays 0 after the first byte of a pair is written. It becomes 1 only when the second byte has been written.
- R5: In paired mode, not-full stays 1 after the first byte of a pair is written. It falls to 0 when the second byte is written, and it returns to 1 only after both bytes have been read.
- R6: In paired mode, the bytes are read in the order they were written. The read of the first byte leaves data-available at 1, and the read of the second byte clears it.
- R7: A read while data-available is 0 leaves the read-data output at its previous value and changes no flag.
- R8: `par_nmi` is 1 exactly when `irq_en_o` is 1 and either `par_avail` or `par_nfull` is 1, both judged in the current mode.
- R9: A control write with `ctl_soft`=1 is a single-cycle strobe. It empties both FIFOs, clears both read-data outputs to 0x00 and reloads the dummy byte into the parasite-to-host FIFO. It leaves `mode_o` and `irq_en_o` unchanged and ignores `ctl_mode` and `ctl_irq_en`.
- R10: A control write with `ctl_soft`=0 loads `ctl_mode` into `mode_o` and `ctl_irq_en` into `irq_en_o`. Both are visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_mode | input | 1 | Mode value: 0 single-byte, 1 paired |
| ctl_irq_en | input | 1 | Parasite interrupt enable value |
| ctl_soft | input | 1 | With ctl_wr: soft-reset the channel instead of loading the control bits |
| host_wr | input | 1 | Host writes a byte toward the parasite |
| host_wdata | input | W | Host write data |
| host_rd | input | 1 | Host reads a byte from the parasite |
| host_rdata | output | W | Last byte read by the host |
| host_avail | output | 1 | Parasite-to-host data available |
| host_nfull | output | 1 | Host-to-parasite FIFO can take a write |
| par_wr | input | 1 | Parasite writes a byte toward the host |
| par_wdata | input | W | Parasite write data |
| par_rd | input | 1 | Parasite reads a byte from the host |
| par_rdata | output | W | Last byte read by the parasite |
| par_avail | output | 1 | Host-to-parasite data available |
| par_nfull | output | 1 | Parasite-to-host FIFO can take a write |
| par_nmi | output | 1 | Non-maskable interrupt request to the parasite |
| mode_o | output | 1 | Current mode bit |
| irq_en_o | output | 1 | Current interrupt enable bit |

## Verification
Every strobe is taken at a rising edge. The FIFO contents, flags, read data and control bits it changes appear one edge later. The interrupt follows the flags with no further delay, because it is decoded from registered state. The bench drives inputs just after a falling edge and captures them at the next rising edge. It then compares every output with its own queue model at the following falling edge, so each result is sampled exactly one cycle after the stimulus that causes it. Directed sequences step through the half-pair, ignored-write, empty-read and soft-reset cases. A long random phase follows, and the model compares every output on every cycle of it.

// File: rtl/bch_pkg.sv
package bch_pkg;

    parameter int BYTE_W     = 8;
    parameter int FIFO_DEPTH = 2;

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_PAIR   = 1'b1
    } bch_mode_e;

    typedef struct packed {
        logic avail;
        logic nfull;
    } bch_flags_t;

    // Flags seen by the two sides of one FIFO, judged in the current mode.
    function automatic bch_flags_t bch_flags(bch_mode_e mode, logic empty, logic pair_done);
        bch_flags_t f;
        if (mode == MODE_PAIR) begin
            f.avail = pair_done;
            f.nfull = ~pair_done;
        end else begin
            f.avail = ~empty;
            f.nfull = empty;
        end
        return f;
    endfunction

endpackage

// File: rtl/bch_fifo.sv
module bch_fifo
    import bch_pkg::*;
#(
    parameter int W       = 8,
    parameter int DEPTH   = 2,
    parameter bit PRELOAD = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         init,
    input  bch_mode_e    mode,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    output logic [W-1:0] rdata,
    output bch_flags_t   flags
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count, count_n;
    logic             pair_q;
    logic [W-1:0]     rdata_q;
    logic             wr_ok, rd_ok;

    always_comb flags = bch_flags(mode, count == '0, pair_q);

    // Acceptance is mutually exclusive in both modes by the flag definitions.
    assign wr_ok = wr & flags.nfull;
    assign rd_ok = rd & flags.avail;

    always_comb begin
        count_n = count;
        if (wr_ok)      count_n = count + CNT_W'(1);
        else if (rd_ok) count_n = count - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || init) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            wr_ptr  <= PTR_W'(PRELOAD);
            rd_ptr  <= '0;
            count   <= CNT_W'(PRELOAD);
            pair_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (wr_ok) begin
                mem[wr_ptr] <= wdata;
                wr_ptr      <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + PTR_W'(1);
            end
            if (rd_ok) begin
                rdata_q <= mem[rd_ptr];
                rd_ptr  <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + PTR_W'(1);
            end
            count <= count_n;
            if (count_n == CNT_W'(DEPTH))
                pair_q <= 1'b1;
            else if (count_n == '0)
                pair_q <= 1'b0;
        end
    end

    assign rdata = rdata_q;

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // R7
    empty_read_chk: assert property (@(posedge clk) disable iff (rst)
        rd && !flags.avail && !init |=> $stable(rdata));

    // R4
    pair_avail_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.avail) && mode == MODE_PAIR && $past(mode) == MODE_PAIR
        |-> count == CNT_W'(DEPTH));

    // R5
    pair_nfull_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.nfull) && mode == MODE_PAIR && $past(mode) == MODE_PAIR
        && !$past(init) |-> count == '0);

endmodule

// File: rtl/bch_ctrl.sv
module bch_ctrl
    import bch_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ctl_wr,
    input  logic      ctl_mode,
    input  logic      ctl_irq_en,
    input  logic      ctl_soft,
    output bch_mode_e mode,
    output logic      irq_en,
    output logic      init
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= MODE_SINGLE;
            irq_en <= 1'b0;
        end else if (ctl_wr && !ctl_soft) begin
            mode   <= bch_mode_e'(ctl_mode);
            irq_en <= ctl_irq_en;
        end
    end

    // Soft reset is a pulse that lasts only while the strobe is present.
    assign init = ctl_wr & ctl_soft;

    // R9
    soft_keeps_ctl_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_wr && ctl_soft |=> $stable(mode) && $stable(irq_en));

    // R10
    ctl_load_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_wr && !ctl_soft |=> (mode == bch_mode_e'($past(ctl_mode))) && (irq_en == $past(ctl_irq_en)));

endmodule

// File: rtl/dual_mode_byte_channel.sv
module dual_mode_byte_channel
    import bch_pkg::*;
#(
    parameter int W     = bch_pkg::BYTE_W,
    parameter int DEPTH = bch_pkg::FIFO_DEPTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ctl_wr,
    input  logic         ctl_mode,
    input  logic         ctl_irq_en,
    input  logic         ctl_soft,
    input  logic         host_wr,
    input  logic [W-1:0] host_wdata,
    input  logic         host_rd,
    output logic [W-1:0] host_rdata,
    output logic         host_avail,
    output logic         host_nfull,
    input  logic         par_wr,
    input  logic [W-1:0] par_wdata,
    input  logic         par_rd,
    output logic [W-1:0] par_rdata,
    output logic         par_avail,
    output logic         par_nfull,
    output logic         par_nmi,
    output logic         mode_o,
    output logic         irq_en_o
);

    localparam int NDIR = 2;   // 0: host to parasite, 1: parasite to host

    bch_mode_e    mode;
    logic         irq_en;
    logic         init;

    logic         dir_wr    [NDIR];
    logic [W-1:0] dir_wdata [NDIR];
    logic         dir_rd    [NDIR];
    logic [W-1:0] dir_rdata [NDIR];
    bch_flags_t   dir_flags [NDIR];

    bch_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .ctl_wr     (ctl_wr),
        .ctl_mode   (ctl_mode),
        .ctl_irq_en (ctl_irq_en),
        .ctl_soft   (ctl_soft),
        .mode       (mode),
        .irq_en     (irq_en),
        .init       (init)
    );

    assign dir_wr[0]    = host_wr;
    assign dir_wdata[0] = host_wdata;
    assign dir_rd[0]    = par_rd;
    assign dir_wr[1]    = par_wr;
    assign dir_wdata[1] = par_wdata;
    assign dir_rd[1]    = host_rd;

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        bch_fifo #(
            .W       (W),
            .DEPTH   (DEPTH),
            .PRELOAD (d == 1)
        ) u_fifo (
            .clk   (clk),
            .rst   (rst),
            .init  (init),
            .mode  (mode),
            .wr    (dir_wr[d]),
            .wdata (dir_wdata[d]),
            .rd    (dir_rd[d]),
            .rdata (dir_rdata[d]),
            .flags (dir_flags[d])
        );
    end

    assign par_rdata  = dir_rdata[0];
    assign par_avail  = dir_flags[0].avail;
    assign host_nfull = dir_flags[0].nfull;
    assign host_rdata = dir_rdata[1];
    assign host_avail = dir_flags[1].avail;
    assign par_nfull  = dir_flags[1].nfull;

    assign par_nmi  = irq_en & (par_avail | par_nfull);
    assign mode_o   = mode;
    assign irq_en_o = irq_en;

    // R8
    nmi_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_en_o |-> !par_nmi);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> host_avail && !par_nfull && !par_nmi && !par_avail && host_nfull);

endmodule

// File: tb/sim_dual_mode_byte_channel.sv
module sim_dual_mode_byte_channel;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_wr = 0, ctl_mode = 0, ctl_irq_en = 0, ctl_soft = 0;
    logic       host_wr = 0, host_rd = 0, par_wr = 0, par_rd = 0;
    logic [7:0] host_wdata = 0, par_wdata = 0;
    logic [7:0] host_rdata, par_rdata;
    logic       host_avail, host_nfull, par_avail, par_nfull, par_nmi, mode_o, irq_en_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;

    always #2 clk = ~clk;   // 250 MHz

    dual_mode_byte_channel u0 (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_mode(ctl_mode),
        .ctl_irq_en(ctl_irq_en), .ctl_soft(ctl_soft),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
        .host_rdata(host_rdata), .host_avail(host_avail), .host_nfull(host_nfull),
        .par_wr(par_wr), .par_wdata(par_wdata), .par_rd(par_rd),
        .par_rdata(par_rdata), .par_avail(par_avail), .par_nfull(par_nfull),
        .par_nmi(par_nmi), .mode_o(mode_o), .irq_en_o(irq_en_o)
    );

    // Behavioural reference model
    bit [7:0] q0[$];   // host to parasite
    bit [7:0] q1[$];   // parasite to host
    bit       pair0, pair1, mode_m, en_m;
    bit [7:0] rd0, rd1;

    function automatic bit avail_f(int n, bit p, bit m);
        return m ? p : (n != 0);
    endfunction
    function automatic bit nfull_f(int n, bit p, bit m);
        return m ? !p : (n == 0);
    endfunction

    task automatic model_init(bit hard);
        q0.delete();
        q1.delete();
        q1.push_back(8'h00);
        pair0 = 0; pair1 = 0; rd0 = 0; rd1 = 0;
        if (hard) begin mode_m = 0; en_m = 0; end
    endtask

    always @(posedge clk) begin
        if (rst) model_init(1);
        else if (ctl_wr && ctl_soft) model_init(0);
        else begin
            bit w0, r0, w1, r1;
            w0 = host_wr && nfull_f(q0.size(), pair0, mode_m);
            r0 = par_rd  && avail_f(q0.size(), pair0, mode_m);
            w1 = par_wr  && nfull_f(q1.size(), pair1, mode_m);
            r1 = host_rd && avail_f(q1.size(), pair1, mode_m);
            if (w0) q0.push_back(host_wdata);
            if (r0) rd0 = q0.pop_front();
            if (w1) q1.push_back(par_wdata);
            if (r1) rd1 = q1.pop_front();
            if (q0.size() == 2) pair0 = 1; else if (q0.size() == 0) pair0 = 0;
            if (q1.size() == 2) pair1 = 1; else if (q1.size() == 0) pair1 = 0;
            if (ctl_wr) begin mode_m = ctl_mode; en_m = ctl_irq_en; end
        end
    end

    task automatic chk(string tag, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, got, exp, $time);
        end
    endtask

    // Compare every output with the model on every falling edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit pa, pn, ha, hn;
            pa = avail_f(q0.size(), pair0, mode_m);
            hn = nfull_f(q0.size(), pair0, mode_m);
            ha = avail_f(q1.size(), pair1, mode_m);
            pn = nfull_f(q1.size(), pair1, mode_m);
            chk(mode_m ? "R4" : "R3", "par_avail",  par_avail,  pa);
            chk(mode_m ? "R4" : "R3", "host_avail", host_avail, ha);
            chk(mode_m ? "R5" : "R3", "host_nfull", host_nfull, hn);
            chk(mode_m ? "R5" : "R3", "par_nfull",  par_nfull,  pn);
            chk(mode_m ? "R6" : "R2", "par_rdata",  par_rdata,  rd0);
            chk(mode_m ? "R6" : "R2", "host_rdata", host_rdata, rd1);
            chk("R8",  "par_nmi",  par_nmi,  en_m & (pa | pn));
            chk("R10", "mode_o",   mode_o,   mode_m);
            chk("R10", "irq_en_o", irq_en_o, en_m);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic tick();
        @(negedge clk);
        ctl_wr = 0; ctl_soft = 0; host_wr = 0; host_rd = 0; par_wr = 0; par_rd = 0;
    endtask
    task automatic ctl(bit m, bit e, bit s);
        ctl_wr = 1; ctl_mode = m; ctl_irq_en = e; ctl_soft = s; tick();
    endtask
    task automatic hwr(bit [7:0] d); host_wr = 1; host_wdata = d; tick(); endtask
    task automatic pwr(bit [7:0] d); par_wr = 1; par_wdata = d; tick(); endtask
    task automatic hrd(); host_rd = 1; tick(); endtask
    task automatic prd(); par_rd = 1; tick(); endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "host_avail", host_avail, 1);
        chk("R1", "par_nfull",  par_nfull,  0);
        chk("R1", "par_avail",  par_avail,  0);
        chk("R1", "host_nfull", host_nfull, 1);
        chk("R1", "par_nmi",    par_nmi,    0);
        chk("R1", "mode_o",     mode_o,     0);
        chk("R1", "irq_en_o",   irq_en_o,   0);
        chk("R1", "host_rdata", host_rdata, 0);

        ctl(0, 1, 0);
        chk("R10", "irq_en_o", irq_en_o, 1);
        chk("R8",  "par_nmi dummy held", par_nmi, 0);
        hrd();
        chk("R1", "dummy byte", host_rdata, 8'h00);
        chk("R8", "par_nmi after dummy read", par_nmi, 1);

        // single-byte mode
        hwr(8'hA5);
        chk("R3", "par_avail one byte", par_avail, 1);
        chk("R3", "host_nfull one byte", host_nfull, 0);
        hwr(8'h3C);
        prd();
        chk("R2", "par_rdata", par_rdata, 8'hA5);
        chk("R3", "second write ignored", par_avail, 0);
        prd();
        chk("R7", "empty read keeps data", par_rdata, 8'hA5);
        chk("R7", "empty read keeps nfull", host_nfull, 1);
        pwr(8'h11);
        hrd();
        chk("R2", "host_rdata", host_rdata, 8'h11);

        // paired mode
        ctl(1, 1, 0);
        chk("R10", "mode_o", mode_o, 1);
        hwr(8'h01);
        chk("R4", "half pair not available", par_avail, 0);
        chk("R5", "half pair still not full", host_nfull, 1);
        hwr(8'h02);
        chk("R4", "pair available", par_avail, 1);
        chk("R5", "pair full", host_nfull, 0);
        hwr(8'h03);
        prd();
        chk("R6", "first byte", par_rdata, 8'h01);
        chk("R6", "avail after first read", par_avail, 1);
        chk("R5", "nfull after first read", host_nfull, 0);
        prd();
        chk("R6", "second byte", par_rdata, 8'h02);
        chk("R6", "avail after second read", par_avail, 0);
        chk("R5", "nfull after second read", host_nfull, 1);
        prd();
        chk("R7", "empty read in pair mode", par_rdata, 8'h02);
        pwr(8'h7E);
        chk("R4", "host half pair", host_avail, 0);
        pwr(8'h7F);
        chk("R4", "host pair", host_avail, 1);
        chk("R8", "nmi quiet", par_nmi, 0);

        // soft reset
        ctl(0, 0, 1);
        chk("R9", "mode kept", mode_o, 1);
        chk("R9", "enable kept", irq_en_o, 1);
        chk("R9", "par_nfull after soft", par_nfull, 1);
        ctl(0, 1, 0);
        chk("R9", "dummy reloaded", host_avail, 1);
        hrd();
        chk("R9", "dummy value", host_rdata, 8'h00);

        // random phase, checked by the model every cycle
        for (int i = 0; i < 3000; i++) begin
            host_wr = 1'($urandom % 2); host_wdata = 8'($urandom);
            par_wr  = 1'($urandom % 2); par_wdata  = 8'($urandom);
            host_rd = 1'($urandom % 2); par_rd     = 1'($urandom % 2);
            ctl_wr  = ($urandom % 16) == 0;
            ctl_mode = 1'($urandom % 2); ctl_irq_en = 1'($urandom % 2);
            ctl_soft = ($urandom % 4) == 0;
            tick();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule